// File: doc/BRIEF.md
# Multi-channel general-purpose timer

This block is a register-mapped timer with six independent counting channels, numbered 1 to 6. Every channel counts upward, either once per system clock or once per rising edge of a slow 32 kHz input, optionally halved by a divide-by-two stage. A channel runs in one of three modes. In one-shot mode it stops at its compare value. In repeat mode it reloads to zero at its compare value and keeps running. In free-running mode it wraps at full width and never matches. The last channel carries a 64-bit count, so it can serve as a long-running time base.

All channels share an interrupt enable register, a pending-status register and a write-one-to-acknowledge register. Channel n owns bit n-1 of each. A compare match always latches the channel's status bit. The single interrupt line is raised while any latched status bit has its enable bit set. Software reaches the block through a simple word-wide bus. A write takes effect on the clock edge at which it is presented. A read returns data combinationally for the address on the bus.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads zero (interrupt enable, status, every channel's control, clock, counter and compare, and the upper counter word) and `irqOut` is low.
- R2: The interrupt enable register sits at 0x00 and keeps bits [5:0]. The status register at 0x04 is read-only. The acknowledge register at 0x08 reads zero. Channel n uses bit n-1 in all three.
- R3: Channel n has four registers, each at byte offset 0x10·n plus a fixed offset. Control is at +0x0, with bit 0 as enable and bits [5:4] as mode. Clock select is at +0x4, with bit 4 as source (1 = slow) and bit 0 as divide-by-two. Counter is at +0x8 and compare is at +0xC. Unmapped word addresses read zero.
- R4: An enabled channel on the fast source with divide-by-1 increments once per clock. Its counter equals the number of clock edges after the enabling write edge. A disabled channel holds its count.
- R5: Writing a control word with bit 1 set zeroes the counter at that write's edge, and this takes priority over counting. Bit 1 always reads back as 0.
- R6: In repeat mode (mode 1) with compare C, a step that would bring the count to C sets the status bit and returns the counter to 0, so the period is C ticks and the channel keeps running.
- R7: In one-shot mode (mode 0) with compare C, reaching C sets the status bit, leaves the counter at C and clears the enable bit.
- R8: In free-running mode (mode 3, and the unused mode 2), no status bit is ever set, and a 32-bit counter wraps from 0xFFFFFFFF to 0.
- R9: Channel 6 counts on 64 bits. Its low word reads at 0x68 and its high word at 0x78, and a carry out of the low word increments the high word.
- R10: A write to a channel's counter offset loads that word (0x78 loads the high word of channel 6). The load takes priority over a step in the same cycle.
- R11: Writing 1 to an acknowledge bit clears that status bit, and 0x3F clears all six. A match in the same cycle as the acknowledge leaves the bit set.
- R12: `irqOut` is high exactly when some status bit and its enable bit are both 1. A status bit is latched even when its enable bit is 0.
- R13: On the slow source, each rising edge of `slowClkIn` gives one tick after synchronization. Divide-by-two counts every second tick of either source, starting from the enabling or clearing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, fast tick source |
| rstN | input | 1 | Active-low synchronous reset |
| slowClkIn | input | 1 | Slow 32 kHz clock, asynchronous to `clk` |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one word per asserted cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irqOut | output | 1 | Interrupt request, OR of enabled pending channels |

## Verification
The bench goes after the cycle on which a compare match lands. If the match is off by one, a repeat period comes out as C+1, or a one-shot channel holds C+1 instead of C. It crosses both the 32-bit wrap of a free-running channel and the 32-bit carry into the high word of channel 6. A design that compared against a wrapped count or dropped the carry shows up there as a false status bit or a wrong high word. It clears and loads counters while they are running, which catches a step that wins over the write. It acknowledges a single channel between matches and checks that the interrupt is masked while status is still latched. Slow-source and divide-by-two runs count pulses, which exposes a tick that fires on both edges or a divider phase that is not reset at start.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } runMode_e;

  // Per-channel strobes from the register control to the counter datapath
  typedef struct packed {
    logic clear;
    logic loadLo;
    logic step;
    logic matchOn;
    logic reload;
  } chStrobe_t;

  // Word select inside a 16-byte slot
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CMP  = 2'd3;

  // Word select inside the global slot
  localparam logic [1:0] REG_IEN  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_ACK  = 2'd2;

  // Field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_DIV_BIT   = 0;
  localparam int CLK_SRC_BIT   = 4;

endpackage

// File: rtl/gpt_slow_sync.sv
module gpt_slow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowIn,
  output logic slowTick
);

  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], slowIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  // one-cycle enable on each synchronized rising edge
  assign slowTick = syncQ[STAGES-1] & ~lastQ;

endmodule

// File: rtl/gpt_count.sv
module gpt_count
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chStrobe_t [NUM_CH-1:0]       strobe,
  input  logic                         loadWideHi,
  input  logic [CNT_W-1:0]             loadData,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmpVal,
  output logic [NUM_CH-1:0][CNT_W-1:0] countLo,
  output logic [CNT_W-1:0]             wideHi,
  output logic [NUM_CH-1:0]            hit
);

  localparam int WIDE_IDX = NUM_CH - 1;
  localparam int WIDE_W   = 2 * CNT_W;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == WIDE_IDX) begin : g_wide
      logic [WIDE_W-1:0] cntQ;
      logic [WIDE_W-1:0] cntNext;

      assign cntNext = cntQ + WIDE_W'(1);
      assign hit[i]  = strobe[i].step && strobe[i].matchOn &&
                       (cntNext == {{CNT_W{1'b0}}, cmpVal[i]});

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cntQ <= '0;
        end else if (strobe[i].clear) begin
          cntQ <= '0;
        end else if (strobe[i].loadLo) begin
          cntQ[CNT_W-1:0] <= loadData;
        end else if (loadWideHi) begin
          cntQ[WIDE_W-1:CNT_W] <= loadData;
        end else if (strobe[i].step) begin
          cntQ <= (hit[i] && strobe[i].reload) ? '0 : cntNext;
        end
      end

      assign countLo[i] = cntQ[CNT_W-1:0];
      assign wideHi     = cntQ[WIDE_W-1:CNT_W];
    end else begin : g_narrow
      logic [CNT_W-1:0] cntQ;
      logic [CNT_W-1:0] cntNext;

      assign cntNext = cntQ + CNT_W'(1);
      assign hit[i]  = strobe[i].step && strobe[i].matchOn &&
                       (cntNext == cmpVal[i]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cntQ <= '0;
        end else if (strobe[i].clear) begin
          cntQ <= '0;
        end else if (strobe[i].loadLo) begin
          cntQ <= loadData;
        end else if (strobe[i].step) begin
          cntQ <= (hit[i] && strobe[i].reload) ? '0 : cntNext;
        end
      end

      assign countLo[i] = cntQ;
    end
  end

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWe,
  input  logic [CNT_W-1:0]             busWdata,
  output logic [CNT_W-1:0]             busRdata,
  input  logic                         slowTick,
  input  logic [NUM_CH-1:0][CNT_W-1:0] countLo,
  input  logic [CNT_W-1:0]             wideHi,
  input  logic [NUM_CH-1:0]            hit,
  output chStrobe_t [NUM_CH-1:0]       strobe,
  output logic                         loadWideHi,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmpVal,
  output logic [NUM_CH-1:0]            statusOut,
  output logic [NUM_CH-1:0]            enableOut,
  output logic [NUM_CH-1:0][1:0]       modeOut,
  output logic                         irqOut
);

  localparam int SLOT_W  = ADDR_W - 4;
  localparam int HI_SLOT = NUM_CH + 1;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        regSel;
  logic              aligned;

  assign slot    = busAddr[ADDR_W-1:4];
  assign regSel  = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  logic [NUM_CH-1:0] wrCtrl, wrClk, wrCnt, wrCmp;
  logic              wrIen, wrAck;
  logic [NUM_CH-1:0] ackMask;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wrCtrl[i] = busWe && aligned && (slot == SLOT_W'(i + 1)) && (regSel == REG_CTRL);
      wrClk[i]  = busWe && aligned && (slot == SLOT_W'(i + 1)) && (regSel == REG_CLK);
      wrCnt[i]  = busWe && aligned && (slot == SLOT_W'(i + 1)) && (regSel == REG_CNT);
      wrCmp[i]  = busWe && aligned && (slot == SLOT_W'(i + 1)) && (regSel == REG_CMP);
    end
    wrIen      = busWe && aligned && (slot == '0) && (regSel == REG_IEN);
    wrAck      = busWe && aligned && (slot == '0) && (regSel == REG_ACK);
    loadWideHi = busWe && aligned && (slot == SLOT_W'(HI_SLOT)) && (regSel == REG_CNT);
    ackMask    = wrAck ? busWdata[NUM_CH-1:0] : '0;
  end

  // state
  logic [NUM_CH-1:0]            irqEnQ, statusQ, enableQ, srcQ, divQ, phaseQ;
  runMode_e [NUM_CH-1:0]        modeQ;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpQ;

  // tick qualification
  logic [NUM_CH-1:0] srcTick, stepOk;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      srcTick[i] = srcQ[i] ? slowTick : 1'b1;
      stepOk[i]  = enableQ[i] && srcTick[i] && (!divQ[i] || phaseQ[i]);
      strobe[i].clear   = wrCtrl[i] && busWdata[CTRL_CLR_BIT];
      strobe[i].loadLo  = wrCnt[i];
      strobe[i].step    = stepOk[i];
      strobe[i].matchOn = (modeQ[i] == MODE_ONCE) || (modeQ[i] == MODE_LOOP);
      strobe[i].reload  = (modeQ[i] == MODE_LOOP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ  <= '0;
      statusQ <= '0;
      enableQ <= '0;
      srcQ    <= '0;
      divQ    <= '0;
      phaseQ  <= '0;
      modeQ   <= {NUM_CH{MODE_ONCE}};
      cmpQ    <= '0;
    end else begin
      if (wrIen) irqEnQ <= busWdata[NUM_CH-1:0];
      // a match in the same cycle wins over the acknowledge
      statusQ <= (statusQ & ~ackMask) | hit;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrCtrl[i]) begin
          enableQ[i] <= busWdata[CTRL_EN_BIT];
          modeQ[i]   <= runMode_e'(busWdata[CTRL_MODE_LSB +: 2]);
        end else if (hit[i] && (modeQ[i] == MODE_ONCE)) begin
          enableQ[i] <= 1'b0;
        end
        if (wrClk[i]) begin
          srcQ[i] <= busWdata[CLK_SRC_BIT];
          divQ[i] <= busWdata[CLK_DIV_BIT];
        end
        if (wrCmp[i]) cmpQ[i] <= busWdata;
        if (strobe[i].clear || !enableQ[i]) begin
          phaseQ[i] <= 1'b0;
        end else if (srcTick[i]) begin
          phaseQ[i] <= ~phaseQ[i];
        end
      end
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (aligned) begin
      if (slot == '0) begin
        case (regSel)
          REG_IEN:  busRdata[NUM_CH-1:0] = irqEnQ;
          REG_STAT: busRdata[NUM_CH-1:0] = statusQ;
          default:  busRdata = '0;
        endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (slot == SLOT_W'(i + 1)) begin
          case (regSel)
            REG_CTRL: begin
              busRdata[CTRL_EN_BIT]          = enableQ[i];
              busRdata[CTRL_MODE_LSB +: 2]   = modeQ[i];
            end
            REG_CLK: begin
              busRdata[CLK_SRC_BIT] = srcQ[i];
              busRdata[CLK_DIV_BIT] = divQ[i];
            end
            REG_CNT: busRdata = countLo[i];
            default: busRdata = cmpQ[i];
          endcase
        end
      end
      if ((slot == SLOT_W'(HI_SLOT)) && (regSel == REG_CNT)) busRdata = wideHi;
    end
  end

  assign cmpVal    = cmpQ;
  assign statusOut = statusQ;
  assign enableOut = enableQ;
  assign modeOut   = modeQ;
  assign irqOut    = |(statusQ & irqEnQ);

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClkIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);

  logic                         slowTick;
  chStrobe_t [NUM_CH-1:0]       strobe;
  logic                         loadWideHi;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVal;
  logic [NUM_CH-1:0][CNT_W-1:0] countLo;
  logic [CNT_W-1:0]             wideHi;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            statusBits;
  logic [NUM_CH-1:0]            enableBits;
  logic [NUM_CH-1:0][1:0]       modeBits;

  gpt_slow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .slowIn   (slowClkIn),
    .slowTick (slowTick)
  );

  gpt_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .slowTick   (slowTick),
    .countLo    (countLo),
    .wideHi     (wideHi),
    .hit        (hit),
    .strobe     (strobe),
    .loadWideHi (loadWideHi),
    .cmpVal     (cmpVal),
    .statusOut  (statusBits),
    .enableOut  (enableBits),
    .modeOut    (modeBits),
    .irqOut     (irqOut)
  );

  gpt_count #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadWideHi (loadWideHi),
    .loadData   (busWdata),
    .cmpVal     (cmpVal),
    .countLo    (countLo),
    .wideHi     (wideHi),
    .hit        (hit)
  );

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busWe,
  input logic [NUM_CH-1:0]            wdLow,
  input logic                         rdClrBit,
  input logic [NUM_CH-1:0]            hit,
  input logic [NUM_CH-1:0]            status,
  input logic [NUM_CH-1:0]            enable,
  input logic [NUM_CH-1:0][1:0]       mode,
  input logic [NUM_CH-1:0][CNT_W-1:0] countLo
);

  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(8);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((n + 1) * 16);

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && (busAddr == CTRL_ADDR) && wdLow[1]) |=> (countLo[n] == '0));

    // R5
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == CTRL_ADDR) |-> !rdClrBit);

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit[n] && (mode[n] == 2'd0) && !(busWe && (busAddr == CTRL_ADDR))) |=> !enable[n]);

    // R8
    free_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mode[n] == 2'd3) |-> !hit[n]);

    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && (busAddr == ACK_ADDR) && wdLow[n] && !hit[n]) |=> !status[n]);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      hit[n] |=> status[n]);
  end

endmodule

bind gpt_timer gpt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .wdLow    (busWdata[NUM_CH-1:0]),
  .rdClrBit (busRdata[1]),
  .hit      (hit),
  .status   (statusBits),
  .enable   (enableBits),
  .mode     (modeBits),
  .countLo  (countLo)
);

// File: tb/gpt_timer_bench.sv
module gpt_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowClkIn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  gpt_timer u_gpt_timer (
    .clk       (clk),
    .rstN      (rstN),
    .slowClkIn (slowClkIn),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irqOut    (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write lands on the next rising edge; returns 1 ns after it
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(posedge clk);
    #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic slowPulse();
    slowClkIn = 1'b1;
    waitEdges(5);
    slowClkIn = 1'b0;
    waitEdges(5);
  endtask

  function automatic logic [31:0] expCount(input int unsigned k, input int unsigned c, input bit loop);
    if (loop) return 32'(k % c);
    return (k < c) ? 32'(k) : 32'(c);
  endfunction

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd90210));

    waitEdges(4);
    rstN = 1'b1;
    waitEdges(1);

    // R1 reset state
    rd(8'h00, v); check("R1 irq enable", v, 32'h0);
    rd(8'h04, v); check("R1 status", v, 32'h0);
    rd(8'h10, v); check("R1 ctrl ch1", v, 32'h0);
    rd(8'h68, v); check("R1 count ch6 low", v, 32'h0);
    rd(8'h78, v); check("R1 count ch6 high", v, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R2 / R3 register map
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 enable keeps six bits", v, 32'h3F);
    rd(8'h08, v); check("R2 ack reads zero", v, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h40, 32'h32);
    rd(8'h40, v); check("R5 clear bit reads zero, R3 mode field", v, 32'h30);
    wr(8'h44, 32'h11);
    rd(8'h44, v); check("R3 clock register", v, 32'h11);
    wr(8'h4C, 32'hDEAD_BEEF);
    rd(8'h4C, v); check("R3 compare register", v, 32'hDEAD_BEEF);
    rd(8'h0C, v); check("R3 unmapped reads zero", v, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h40, 32'h0);

    // R4 fast counting
    wr(8'h10, 32'h31);
    waitEdges(10);
    rd(8'h18, v); check("R4 count after 10 edges", v, 32'd10);
    // R5 clear while running
    wr(8'h10, 32'h33);
    rd(8'h18, v); check("R5 clear wins over step", v, 32'd0);
    waitEdges(5);
    rd(8'h18, v); check("R5 count after clear", v, 32'd5);
    wr(8'h10, 32'h30);
    rd(8'h18, v);
    waitEdges(5);
    rd(8'h18, v2); check("R4 disabled channel holds", v2, v);

    // R8 free-run wrap with compare 0, R10 load
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFE);
    rd(8'h18, v); check("R10 load while stopped", v, 32'hFFFF_FFFE);
    wr(8'h10, 32'h31);
    waitEdges(3);
    rd(8'h18, v); check("R8 wrap to 1", v, 32'd1);
    rd(8'h04, v); check("R8 free-run sets no status", v, 32'h0);
    wr(8'h18, 32'd100);
    rd(8'h18, v); check("R10 load wins over step", v, 32'd100);
    waitEdges(4);
    rd(8'h18, v); check("R10 counts on from load", v, 32'd104);
    wr(8'h10, 32'h30);

    // R6 repeat, compare 7, channel 5
    wr(8'h08, 32'h3F);
    wr(8'h5C, 32'd7);
    wr(8'h50, 32'h13);
    waitEdges(6);
    rd(8'h04, v); check("R6 no status before match", v, 32'h0);
    rd(8'h58, v); check("R6 count 6", v, 32'd6);
    waitEdges(1);
    rd(8'h04, v); check("R6 status bit4 at match", v, 32'h10);
    rd(8'h58, v); check("R6 reload to zero", v, 32'd0);
    waitEdges(3);
    wr(8'h08, 32'h10);
    rd(8'h04, v); check("R11 single ack clears", v, 32'h0);
    rd(8'h58, v); check("R6 keeps running", v, 32'd4);
    waitEdges(3);
    rd(8'h04, v); check("R6 second period match", v, 32'h10);
    wr(8'h50, 32'h10);

    // R12 interrupt gating
    check("R12 masked irq", {31'b0, irqOut}, 32'h0);
    wr(8'h00, 32'h10);
    check("R12 enabled irq", {31'b0, irqOut}, 32'h1);
    wr(8'h08, 32'h3F);
    check("R11 ack all drops irq", {31'b0, irqOut}, 32'h0);
    rd(8'h04, v); check("R11 ack all clears", v, 32'h0);
    wr(8'h00, 32'h0);

    // R7 one-shot, compare 5, channel 4
    wr(8'h4C, 32'd5);
    wr(8'h40, 32'h03);
    waitEdges(4);
    rd(8'h04, v); check("R7 no status before match", v, 32'h0);
    waitEdges(1);
    rd(8'h04, v); check("R7 status bit3", v, 32'h08);
    rd(8'h40, v); check("R7 enable cleared", v, 32'h0);
    waitEdges(10);
    rd(8'h48, v); check("R7 count holds compare", v, 32'd5);
    wr(8'h08, 32'h3F);

    // R9 64-bit channel 6
    wr(8'h68, 32'hFFFF_FFF0);
    wr(8'h78, 32'h1);
    rd(8'h78, v); check("R10 high word load", v, 32'h1);
    wr(8'h60, 32'h31);
    waitEdges(20);
    rd(8'h68, v); check("R9 low word after carry", v, 32'd4);
    rd(8'h78, v); check("R9 high word after carry", v, 32'd2);

    // R13 divide-by-two on fast source
    wr(8'h14, 32'h01);
    wr(8'h10, 32'h33);
    waitEdges(9);
    rd(8'h18, v); check("R13 fast div2", v, 32'd4);
    wr(8'h10, 32'h30);
    wr(8'h14, 32'h00);

    // R13 slow source: ch2 div1, ch3 div2
    wr(8'h24, 32'h10);
    wr(8'h34, 32'h11);
    wr(8'h20, 32'h33);
    wr(8'h30, 32'h33);
    for (int p = 0; p < 7; p++) slowPulse();
    waitEdges(6);
    rd(8'h28, v); check("R13 slow div1 pulses", v, 32'd7);
    rd(8'h38, v); check("R13 slow div2 pulses", v, 32'd3);
    wr(8'h20, 32'h30);
    wr(8'h30, 32'h30);

    // R6 / R7 random compare and run length
    for (int it = 0; it < 12; it++) begin
      int unsigned ch, c, k;
      bit loop;
      logic [7:0] base;
      case ($urandom % 3)
        0: ch = 1;
        1: ch = 4;
        default: ch = 5;
      endcase
      c    = 2 + ($urandom % 40);
      k    = 1 + ($urandom % (2 * c));
      loop = bit'($urandom % 2);
      base = 8'(ch * 16);
      wr(base, 32'h0);
      wr(8'h08, 32'h3F);
      wr(base + 8'h0C, 32'(c));
      wr(base, loop ? 32'h13 : 32'h03);
      waitEdges(int'(k));
      rd(base + 8'h08, v);
      check(loop ? "R6 random count" : "R7 random count", v, expCount(k, c, loop));
      rd(8'h04, v);
      check(loop ? "R6 random status" : "R7 random status", v,
            (k >= c) ? (32'h1 << (ch - 1)) : 32'h0);
      wr(base, 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule